// File: doc/BRIEF.md
# Banked Level Interrupt Combiner

This block collects many level-sensitive interrupt sources and funnels them into a smaller number of request lines for a parent interrupt controller. Sources are organised in groups of eight; each group has its own enable bits and its own combined output line, which is high while at least one enabled source in that group is high. Nothing is latched. A request exists only while its source holds the line high.

Four groups share one 32-bit register bank. Each group takes one byte lane of the bank. Software masks and unmasks individual sources through a write-one-to-set register and a write-one-to-clear register. It can see which enabled sources are currently active through a read-only status register. Every raw input first passes through a two-flop synchroniser, so the outputs and the status react a fixed two cycles after an input changes.

The group count is a parameter. When it is not a multiple of four, the upper lanes of the last bank are left without a group.

Top module: `irq_combiner`

## Requirements
- R1: After reset every enable bit is 0, every `irq_out` line is 0, and every register reads 0.
- R2: A write to bank offset 0x0 sets each enable bit whose data bit is 1. Enable bits whose data bit is 0 keep their value.
- R3: A write to bank offset 0x4 clears each enable bit whose data bit is 1. Enable bits whose data bit is 0 keep their value.
- R4: A read of offset 0x0 or of offset 0x4 returns the bank's current enable bits.
- R5: A read of offset 0xC returns the synchronised input levels ANDed with their enables. Group n sits in the bank at address (n div 4)*0x10, in bits [8*(n mod 4)+7 : 8*(n mod 4)]. Global input g*8+k is line k of group g.
- R6: `irq_out[n]` is the OR, over the eight lines of group n, of (synchronised input AND enable). It falls as soon as no enabled input of the group is high.
- R7: An input value present before clock edge t appears at `irq_out` and in the status after edge t+1. After edge t alone, the old value is still shown.
- R8: The following writes change no state: writes to offset 0xC, writes to offset 0x8, writes to a bank index at or above the bank count, and writes with address bits [1:0] not zero. Reads of those addresses return 0.
- R9: Bits of lanes that have no group, in the last bank, cannot be enabled and always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | NUM_GROUPS*8 | Raw level interrupt sources, global index g*8+k |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_wr_en | input | 1 | Write strobe, one write per asserted cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq_out | output | NUM_GROUPS | One combined request line per group |

## Verification
On every cycle, the assertions check four things. First, a set write turns on every bit that carried a 1 and a clear write turns off every such bit. Second, enables stay stable when no decoded write reaches a bank. Third, the bank strobes are mutually exclusive and are never raised by a status or misaligned access. Fourth, the synchroniser output equals the input from two cycles earlier, and lanes without a group never hold an enable. Some behaviour can only be shown by the bench's scenarios: that the lane and bank address arithmetic places each group where the map says, the read values of reserved and out-of-range offsets, and the exact cycle where an output rises after an input change. The bench covers these with directed cases and with constrained-random mixes of inputs and writes.

// File: rtl/irq_comb_pkg.sv
package irq_comb_pkg;

    localparam int LANE_W      = 8;
    localparam int BANK_LANES  = 4;
    localparam int BANK_W      = LANE_W * BANK_LANES;
    localparam int BANK_SHIFT  = 4;

    typedef enum logic [1:0] {
        REG_EN_SET  = 2'd0,
        REG_EN_CLR  = 2'd1,
        REG_RSVD    = 2'd2,
        REG_STATUS  = 2'd3
    } reg_sel_e;

    function automatic logic [BANK_W-1:0] lanes_mask(input int lanes);
        logic [BANK_W-1:0] m;
        m = '0;
        for (int i = 0; i < BANK_W; i++) begin
            if (i < lanes * LANE_W) m[i] = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/irq_comb_sync.sv
module irq_comb_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] raw_i,
    output logic [W-1:0] sync_o
);

    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
        logic [1:0]   age;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.s1  = raw_i;
        st_d.s2  = st_q.s1;
        if (st_q.age != 2'd2) st_d.age = st_q.age + 2'd1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sync_o = st_q.s2;

    // R7: two-cycle latency from raw input to synchronised level
    assert_sync_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.age == 2'd2) |-> (sync_o == $past(raw_i, 2)));

endmodule

// File: rtl/irq_comb_bank.sv
module irq_comb_bank
    import irq_comb_pkg::*;
#(
    parameter int LANES = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_set,
    input  logic                wr_clr,
    input  logic [BANK_W-1:0]   wdata,
    input  logic [LANES*LANE_W-1:0] lvl,
    output logic [BANK_W-1:0]   en_word,
    output logic [BANK_W-1:0]   stat_word,
    output logic [LANES-1:0]    lane_irq
);

    localparam logic [BANK_W-1:0] LANE_MASK = lanes_mask(LANES);

    typedef struct packed {
        logic [BANK_W-1:0] en;
    } bank_st_t;

    bank_st_t st_d, st_q;
    logic [BANK_W-1:0] lvl_pad;

    always_comb begin
        lvl_pad = '0;
        lvl_pad[LANES*LANE_W-1:0] = lvl;
    end

    always_comb begin
        st_d = st_q;
        if (wr_set) st_d.en = st_d.en | (wdata & LANE_MASK);
        if (wr_clr) st_d.en = st_d.en & ~wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign en_word   = st_q.en;
    assign stat_word = st_q.en & lvl_pad;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        assign lane_irq[l] = |stat_word[l*LANE_W +: LANE_W];
    end

    // R2: every written one lands in the enable state
    assert_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_set |=> ((st_q.en & $past(wdata & LANE_MASK)) == $past(wdata & LANE_MASK)));

    // R3: every written one is removed from the enable state
    assert_clr_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_clr |=> ((st_q.en & $past(wdata)) == '0));

    // R8: no strobe, no change
    assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_set && !wr_clr) |=> $stable(st_q.en));

    // R6: with nothing enabled, no lane can request
    assert_masked_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.en == '0) |-> (lane_irq == '0));

    // R9: lanes without a group never hold an enable
    assert_unused_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q.en & ~LANE_MASK) == '0));

endmodule

// File: rtl/irq_combiner.sv
module irq_combiner
    import irq_comb_pkg::*;
#(
    parameter int NUM_GROUPS = 6,
    parameter int ADDR_W     = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [NUM_GROUPS*LANE_W-1:0] irq_in,
    input  logic [ADDR_W-1:0]            bus_addr,
    input  logic                         bus_wr_en,
    input  logic [BANK_W-1:0]            bus_wdata,
    output logic [BANK_W-1:0]            bus_rdata,
    output logic [NUM_GROUPS-1:0]        irq_out
);

    localparam int N_IN      = NUM_GROUPS * LANE_W;
    localparam int NUM_BANKS = (NUM_GROUPS + BANK_LANES - 1) / BANK_LANES;
    localparam int BIDX_W    = ADDR_W - BANK_SHIFT;

    logic [N_IN-1:0]      sync_lvl;
    logic [BIDX_W-1:0]    bidx;
    reg_sel_e             rsel;
    logic                 aligned;
    logic                 bank_ok;
    logic [NUM_BANKS-1:0] bank_set;
    logic [NUM_BANKS-1:0] bank_clr;
    logic [BANK_W-1:0]    en_words   [NUM_BANKS];
    logic [BANK_W-1:0]    stat_words [NUM_BANKS];

    irq_comb_sync #(.W(N_IN)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw_i  (irq_in),
        .sync_o (sync_lvl)
    );

    assign bidx    = bus_addr[ADDR_W-1:BANK_SHIFT];
    assign rsel    = reg_sel_e'(bus_addr[3:2]);
    assign aligned = (bus_addr[1:0] == 2'b00);
    assign bank_ok = aligned && (int'(bidx) < NUM_BANKS);

    always_comb begin
        bank_set = '0;
        bank_clr = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (bus_wr_en && bank_ok && (int'(bidx) == b)) begin
                bank_set[b] = (rsel == REG_EN_SET);
                bank_clr[b] = (rsel == REG_EN_CLR);
            end
        end
    end

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        localparam int REM = NUM_GROUPS - b * BANK_LANES;
        localparam int L   = (REM > BANK_LANES) ? BANK_LANES : REM;

        irq_comb_bank #(.LANES(L)) u_bank (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_set    (bank_set[b]),
            .wr_clr    (bank_clr[b]),
            .wdata     (bus_wdata),
            .lvl       (sync_lvl[b*BANK_W +: L*LANE_W]),
            .en_word   (en_words[b]),
            .stat_word (stat_words[b]),
            .lane_irq  (irq_out[b*BANK_LANES +: L])
        );
    end

    always_comb begin
        bus_rdata = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (bank_ok && (int'(bidx) == b)) begin
                case (rsel)
                    REG_EN_SET, REG_EN_CLR: bus_rdata = en_words[b];
                    REG_STATUS:             bus_rdata = stat_words[b];
                    default:                bus_rdata = '0;
                endcase
            end
        end
    end

    // R8: at most one bank strobe per cycle
    assert_dec_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({bank_set, bank_clr}));

    // R8: status, reserved and misaligned writes raise no strobe
    assert_dec_ignore_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr_en && (!aligned || rsel == REG_STATUS || rsel == REG_RSVD))
            |-> ((bank_set == '0) && (bank_clr == '0)));

endmodule

// File: tb/irq_combiner_tb.sv
`timescale 1ns/1ps
module irq_combiner_tb_top;

    localparam int NG    = 6;
    localparam int AW    = 8;
    localparam int NIN   = NG * 8;
    localparam int NB    = (NG + 3) / 4;
    localparam real TCLK = 8.0;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NIN-1:0]  irq_in = '0;
    logic [AW-1:0]   bus_addr = '0;
    logic            bus_wr_en = 1'b0;
    logic [31:0]     bus_wdata = '0;
    logic [31:0]     bus_rdata;
    logic [NG-1:0]   irq_out;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 0;

    logic [NIN-1:0]  m1 = '0, m2 = '0;
    logic [NB*32-1:0] en_m = '0;

    always #(TCLK/2) clk = ~clk;

    irq_combiner #(.NUM_GROUPS(NG), .ADDR_W(AW)) dut_i (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .bus_addr(bus_addr),
        .bus_wr_en(bus_wr_en), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_out(irq_out)
    );

    // two-cycle latency model from R7
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin m1 <= '0; m2 <= '0; end
        else begin m1 <= irq_in; m2 <= m1; end
    end

    function automatic logic [NB*32-1:0] valid_bits();
        logic [NB*32-1:0] v = '0;
        for (int i = 0; i < NB*32; i++) if (i < NIN) v[i] = 1'b1;
        return v;
    endfunction

    function automatic logic [NB*32-1:0] lvl_pad();
        logic [NB*32-1:0] v = '0;
        v[NIN-1:0] = m2;
        return v;
    endfunction

    function automatic logic [NG-1:0] exp_out();
        logic [NB*32-1:0] s = lvl_pad() & en_m;
        logic [NG-1:0] o;
        for (int g = 0; g < NG; g++) o[g] = |s[g*8 +: 8];
        return o;
    endfunction

    function automatic logic [31:0] exp_read(input logic [AW-1:0] a);
        int b = int'(a >> 4);
        if (a[1:0] != 2'b00 || b >= NB) return 32'h0;
        case (a[3:2])
            2'd0, 2'd1: return en_m[b*32 +: 32];
            2'd3:       return (lvl_pad() & en_m) >> (b*32);
            default:    return 32'h0;
        endcase
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
        int b;
        bus_addr = a; bus_wdata = d; bus_wr_en = 1'b1;
        @(posedge clk);
        b = int'(a >> 4);
        if (a[1:0] == 2'b00 && b < NB) begin
            if (a[3:2] == 2'd0) en_m[b*32 +: 32] = en_m[b*32 +: 32] | (d & valid_bits() >> (b*32));
            if (a[3:2] == 2'd1) en_m[b*32 +: 32] = en_m[b*32 +: 32] & ~d;
        end
        #1 bus_wr_en = 1'b0;
    endtask

    task automatic rd(input string tag, input logic [AW-1:0] a);
        bus_addr = a; #1;
        chk(tag, 64'(bus_rdata), 64'(exp_read(a)));
    endtask

    task automatic rd_val(input string tag, input logic [AW-1:0] a, input logic [31:0] v);
        bus_addr = a; #1;
        chk(tag, 64'(bus_rdata), 64'(v));
    endtask

    initial begin
        #(TCLK * 150000);
        if (!done) begin
            n_errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        int seed;
        seed = $urandom(32'd20240611);
        repeat (3) step();
        rst_n = 1'b1;
        step();

        // R1: reset state
        chk("R1 irq_out", 64'(irq_out), 64'h0);
        rd_val("R1 set reg b0", 8'h00, 32'h0);
        rd_val("R1 clr reg b1", 8'h14, 32'h0);
        rd_val("R1 status b0", 8'h0C, 32'h0);

        // R6: all inputs high but masked
        irq_in = '1;
        repeat (3) step();
        chk("R6 masked", 64'(irq_out), 64'h0);

        // R2: set one bit of group 0, zero bits leave others
        wr(8'h00, 32'h0000_0008);
        chk("R6 grp0 high", 64'(irq_out), 64'h01);
        wr(8'h00, 32'h0000_0100);
        rd_val("R2 set accum", 8'h00, 32'h0000_0108);
        rd_val("R4 read via clr offset", 8'h04, 32'h0000_0108);

        // R3: clear only written ones
        wr(8'h04, 32'h0000_0008);
        rd_val("R3 clr partial", 8'h00, 32'h0000_0100);
        chk("R6 grp1 only", 64'(irq_out), 64'h02);

        // R5: group 5 sits at bank 1 lane 1, global line 5*8+3 = 43
        wr(8'h10, 32'h0000_0800);
        irq_in = '0; irq_in[43] = 1'b1;
        repeat (2) step();
        rd_val("R5 status grp5", 8'h1C, 32'h0000_0800);
        chk("R5 out grp5", 64'(irq_out), 64'h20);

        // R7: latency, input rises at line 43 after drop
        irq_in[43] = 1'b0;
        repeat (3) step();
        chk("R6 falls", 64'(irq_out), 64'h00);
        irq_in[43] = 1'b1;
        step();
        chk("R7 after one edge", 64'(irq_out), 64'h00);
        step();
        chk("R7 after two edges", 64'(irq_out), 64'h20);

        // R9: unused lanes of bank 1
        wr(8'h10, 32'hFFFF_FFFF);
        rd_val("R9 upper lanes zero", 8'h10, 32'h0000_FFFF);
        irq_in = '1;
        repeat (2) step();
        rd_val("R9 status upper zero", 8'h1C, 32'h0000_FFFF);

        // R8: ignored writes and zero reads
        wr(8'h0C, 32'hFFFF_FFFF);
        wr(8'h08, 32'hFFFF_FFFF);
        wr(8'h20, 32'hFFFF_FFFF);
        wr(8'h05, 32'hFFFF_FFFF);
        rd_val("R8 bank0 unchanged", 8'h00, 32'h0000_0100);
        rd_val("R8 bank1 unchanged", 8'h10, 32'h0000_FFFF);
        rd_val("R8 reserved read", 8'h08, 32'h0);
        rd_val("R8 out of range read", 8'h20, 32'h0);
        rd_val("R8 misaligned read", 8'h01, 32'h0);

        // R3: clear everything
        wr(8'h04, 32'hFFFF_FFFF);
        wr(8'h14, 32'hFFFF_FFFF);
        chk("R3 all cleared", 64'(irq_out), 64'h0);

        // random mix: R2 R3 R4 R5 R6 R7 R8
        for (int it = 0; it < 2000; it++) begin
            int op;
            logic [AW-1:0] a;
            logic [63:0] r;
            r = {$urandom(), $urandom()};
            if ($urandom_range(3) == 0) irq_in = r[NIN-1:0];
            op = $urandom_range(3);
            a = AW'($urandom_range(47));
            if ($urandom_range(7) != 0) a[1:0] = 2'b00;
            if (op == 0) wr(a, $urandom());
            else step();
            chk("R6 random irq_out", 64'(irq_out), 64'(exp_out()));
            if (op >= 2) rd("R5 random read", a);
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule